// File: doc/BRIEF.md
# Block-Stride Scratchpad Transfer Engine

This engine moves words between an off-chip memory port and a processor's private scratchpad under software control. Software presents a descriptor on the command port and pulses start. The descriptor holds a direction, an off-chip word base, a scratchpad word offset, a block length, a stride and a block count. A load gathers `count` blocks of `length` words, each block starting `stride` words after the previous one, and packs them back to back into the scratchpad. A store reads a packed scratchpad region and scatters it to the same strided off-chip layout. When the stride equals the block length, the transfer is one contiguous run. The scratchpad holds 6144 words, organised as three 2048-word pages.

The controller is a six-state machine. S_IDLE accepts a start. From S_IDLE, the transition *accept-load* goes to S_LOAD and *accept-store* goes to S_SPRD. A descriptor that is empty or out of range takes the transition *finish-now* to S_FINISH. In S_LOAD, reads are issued while fewer than four are outstanding. The transition *last-issued* moves the machine to S_DRAIN, and *all-returned* moves it from S_DRAIN to S_FINISH. A store alternates S_SPRD (scratchpad read) and S_STWR (memory write). The transition *word-granted* returns from S_STWR to S_SPRD, and *last-granted* goes from S_STWR to S_FINISH. S_FINISH pulses done and takes *retire* back to S_IDLE.

Top module: `stride_xfer_engine`

## Requirements
- R1: After reset, busy, done, err_busy, err_range, mem_req and spm_en are all 0.
- R2: A load (cmd_dir=0) issues read requests in order. Word j of block i is read from address ext_base + i*stride + j, with block-major order and 32-bit wrap.
- R3: A store (cmd_dir=1) writes scratchpad word spm_base+n to the off-chip address of the n-th word of the same (i,j) order. Writes expect no response.
- R4: When stride equals block length, the read addresses are exactly ext_base, ext_base+1, and so on.
- R5: No more than 4 reads are outstanding at any time. A request that is not granted stays asserted with an unchanged address and direction.
- R6: busy is 1 from the cycle after an accepted start through the done cycle. done is a single-cycle pulse, and busy is 0 in the cycle after it.
- R7: A descriptor with zero length or zero count raises done in the cycle after the start. It makes no memory or scratchpad access and sets no error.
- R8: A descriptor with spm_base + length*count > 6144 is rejected. It raises done in the cycle after the start, sets err_range, and makes no access. A descriptor ending exactly at 6144 runs normally.
- R9: A start while busy is ignored and sets err_busy. The running transfer is unaffected. err_busy and err_range clear on the next accepted start.
- R10: Read responses arrive in order after any latency, and the n-th response is written to scratchpad word spm_base+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for the presented descriptor |
| cmd_dir | input | 1 | 0 = load into scratchpad, 1 = store from scratchpad |
| cmd_ext_base | input | 32 | Off-chip word base address |
| cmd_spm_base | input | 13 | Scratchpad word offset |
| cmd_blk_len | input | 16 | Words per block |
| cmd_stride | input | 32 | Word distance between block starts |
| cmd_blk_cnt | input | 16 | Number of blocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_busy | output | 1 | A start arrived while busy |
| err_range | output | 1 | Last descriptor overran the scratchpad |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| spm_en | output | 1 | Scratchpad access enable |
| spm_we | output | 1 | Scratchpad write |
| spm_addr | output | 13 | Scratchpad word address |
| spm_wdata | output | 32 | Scratchpad write data |
| spm_rdata | input | 32 | Scratchpad read data, valid the cycle after a read |

## Verification
Reaching the outstanding-read ceiling is hard, because it needs read grants to arrive faster than responses return. The bench grants every cycle and holds each response back by eight cycles, so a contiguous load fills all four slots. The scoreboard records the largest number of reads it saw in flight. A start that is ignored while busy is also hard to observe, because an ignored command leaves nothing behind. The bench presents a store descriptor in the middle of a long load. Any stray write would then pop an empty expectation queue and be reported.

// File: rtl/sxe_pkg.sv
package sxe_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_DRAIN,
        S_SPRD,
        S_STWR,
        S_FINISH
    } sxe_state_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } sxe_dir_e;

endpackage

// File: rtl/sxe_addr_gen.sv
module sxe_addr_gen #(
    parameter int AW       = 32,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic [AW-1:0]       init_base,
    input  logic [LEN_W-1:0]    init_len,
    input  logic [CNT_W-1:0]    init_cnt,
    input  logic [STRIDE_W-1:0] init_stride,
    input  logic                step,
    output logic [AW-1:0]       addr,
    output logic                last
);

    logic [LEN_W-1:0]    len_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [AW-1:0]       blk_base_q;
    logic [LEN_W-1:0]    word_q;
    logic [CNT_W-1:0]    blk_q;
    logic                word_last;
    logic                blk_last;

    assign word_last = (word_q == len_q - LEN_W'(1));
    assign blk_last  = (blk_q == cnt_q - CNT_W'(1));
    assign last      = word_last && blk_last;
    assign addr      = blk_base_q + AW'(word_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q      <= '0;
            cnt_q      <= '0;
            stride_q   <= '0;
            blk_base_q <= '0;
            word_q     <= '0;
            blk_q      <= '0;
        end else if (init) begin
            len_q      <= init_len;
            cnt_q      <= init_cnt;
            stride_q   <= init_stride;
            blk_base_q <= init_base;
            word_q     <= '0;
            blk_q      <= '0;
        end else if (step) begin
            if (word_last) begin
                word_q     <= '0;
                blk_q      <= blk_q + CNT_W'(1);
                blk_base_q <= blk_base_q + AW'(stride_q);
            end else begin
                word_q <= word_q + LEN_W'(1);
            end
        end
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && !word_last) |=> (addr == $past(addr) + AW'(1)));

endmodule

// File: rtl/sxe_rd_track.sv
module sxe_rd_track #(
    parameter int MAX_OUT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic retire,
    output logic can_issue,
    output logic idle
);

    localparam int CW = $clog2(MAX_OUT + 1);

    logic [CW-1:0] cnt_q;

    assign can_issue = (cnt_q < CW'(MAX_OUT));
    assign idle      = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({issue, retire})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R5
    out_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_OUT));

    // R10
    no_orphan_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (cnt_q != '0));

endmodule

// File: rtl/sxe_span_chk.sv
module sxe_span_chk #(
    parameter int SPM_AW    = 13,
    parameter int SPM_WORDS = 6144,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 16
) (
    input  logic [SPM_AW-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [CNT_W-1:0]  cnt,
    output logic              empty,
    output logic              over
);

    localparam int TW = LEN_W + CNT_W + 1;

    logic [TW-1:0] total;
    logic [TW-1:0] end_w;

    assign total = TW'(len) * TW'(cnt);
    assign end_w = TW'(base) + total;
    assign empty = (len == '0) || (cnt == '0);
    assign over  = (end_w > TW'(SPM_WORDS));

endmodule

// File: rtl/stride_xfer_engine.sv
module stride_xfer_engine
    import sxe_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int SPM_AW    = 13,
    parameter int SPM_WORDS = 6144,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 16,
    parameter int STRIDE_W  = 32,
    parameter int MAX_OUT   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_dir,
    input  logic [AW-1:0]       cmd_ext_base,
    input  logic [SPM_AW-1:0]   cmd_spm_base,
    input  logic [LEN_W-1:0]    cmd_blk_len,
    input  logic [STRIDE_W-1:0] cmd_stride,
    input  logic [CNT_W-1:0]    cmd_blk_cnt,
    output logic                busy,
    output logic                done,
    output logic                err_busy,
    output logic                err_range,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [DW-1:0]       mem_rdata,
    output logic                spm_en,
    output logic                spm_we,
    output logic [SPM_AW-1:0]   spm_addr,
    output logic [DW-1:0]       spm_wdata,
    input  logic [DW-1:0]       spm_rdata
);

    sxe_state_e        state_q;
    sxe_state_e        state_d;
    logic [SPM_AW-1:0] spm_ptr_q;
    logic              fresh_q;
    logic [DW-1:0]     hold_q;
    logic              err_busy_q;
    logic              err_range_q;

    logic              accept;
    logic              desc_empty;
    logic              desc_over;
    logic              gen_step;
    logic              gen_last;
    logic [AW-1:0]     gen_addr;
    logic              rd_issue;
    logic              rd_retire;
    logic              can_issue;
    logic              rd_idle;
    logic              in_load;

    assign accept    = (state_q == S_IDLE) && cmd_start;
    assign in_load   = (state_q == S_LOAD) || (state_q == S_DRAIN);
    assign gen_step  = mem_req && mem_gnt;
    assign rd_issue  = gen_step && !mem_we;
    assign rd_retire = mem_rvalid && in_load;

    sxe_span_chk #(
        .SPM_AW    (SPM_AW),
        .SPM_WORDS (SPM_WORDS),
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W)
    ) span_i (
        .base  (cmd_spm_base),
        .len   (cmd_blk_len),
        .cnt   (cmd_blk_cnt),
        .empty (desc_empty),
        .over  (desc_over)
    );

    sxe_addr_gen #(
        .AW       (AW),
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W),
        .STRIDE_W (STRIDE_W)
    ) gen_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (accept),
        .init_base   (cmd_ext_base),
        .init_len    (cmd_blk_len),
        .init_cnt    (cmd_blk_cnt),
        .init_stride (cmd_stride),
        .step        (gen_step),
        .addr        (gen_addr),
        .last        (gen_last)
    );

    sxe_rd_track #(
        .MAX_OUT (MAX_OUT)
    ) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (rd_issue),
        .retire    (rd_retire),
        .can_issue (can_issue),
        .idle      (rd_idle)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_start) begin
                    if (desc_empty || desc_over)
                        state_d = S_FINISH;
                    else if (cmd_dir == DIR_STORE)
                        state_d = S_SPRD;
                    else
                        state_d = S_LOAD;
                end
            end
            S_LOAD: begin
                if (gen_step && gen_last)
                    state_d = S_DRAIN;
            end
            S_DRAIN: begin
                if (rd_idle)
                    state_d = S_FINISH;
            end
            S_SPRD: begin
                state_d = S_STWR;
            end
            S_STWR: begin
                if (gen_step)
                    state_d = gen_last ? S_FINISH : S_SPRD;
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        spm_en  = 1'b0;
        spm_we  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_LOAD: begin
                busy    = 1'b1;
                mem_req = can_issue;
            end
            S_DRAIN: begin
                busy = 1'b1;
            end
            S_SPRD: begin
                busy   = 1'b1;
                spm_en = 1'b1;
            end
            S_STWR: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
            end
        endcase
        if (rd_retire) begin
            spm_en = 1'b1;
            spm_we = 1'b1;
        end
        mem_addr  = gen_addr;
        mem_wdata = fresh_q ? spm_rdata : hold_q;
        spm_addr  = spm_ptr_q;
        spm_wdata = mem_rdata;
        err_busy  = err_busy_q;
        err_range = err_range_q;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spm_ptr_q   <= '0;
            fresh_q     <= 1'b0;
            hold_q      <= '0;
            err_busy_q  <= 1'b0;
            err_range_q <= 1'b0;
        end else begin
            fresh_q <= (state_q == S_SPRD);
            if (state_q == S_STWR)
                hold_q <= mem_wdata;
            if (accept)
                spm_ptr_q <= cmd_spm_base;
            else if (spm_en)
                spm_ptr_q <= spm_ptr_q + SPM_AW'(1);
            if (accept) begin
                err_busy_q  <= 1'b0;
                err_range_q <= !desc_empty && desc_over;
            end else if (cmd_start) begin
                err_busy_q <= 1'b1;
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || spm_en) |-> busy);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    spm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spm_en |-> (32'(spm_addr) < 32'(SPM_WORDS)));

    // R7
    empty_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_start && desc_empty) |=> (done && !mem_req && !spm_en && !err_range));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && busy) |=> err_busy);

endmodule

// File: tb/stride_xfer_engine_tb_top.sv
module stride_xfer_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_start;
    logic        cmd_dir;
    logic [31:0] cmd_ext_base;
    logic [12:0] cmd_spm_base;
    logic [15:0] cmd_blk_len;
    logic [31:0] cmd_stride;
    logic [15:0] cmd_blk_cnt;
    logic        busy, done, err_busy, err_range;
    logic        mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        spm_en, spm_we;
    logic [12:0] spm_addr;
    logic [31:0] spm_wdata, spm_rdata;

    always #10 clk = ~clk;

    stride_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir), .cmd_ext_base(cmd_ext_base),
        .cmd_spm_base(cmd_spm_base), .cmd_blk_len(cmd_blk_len), .cmd_stride(cmd_stride),
        .cmd_blk_cnt(cmd_blk_cnt),
        .busy(busy), .done(done), .err_busy(err_busy), .err_range(err_range),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .spm_en(spm_en), .spm_we(spm_we), .spm_addr(spm_addr), .spm_wdata(spm_wdata),
        .spm_rdata(spm_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int track_out = 0;
    int max_out = 0;
    int done_cnt = 0;
    int act_cnt = 0;
    int last_ready = 0;
    bit gnt_rand = 0;
    bit lat_long = 0;
    string rd_tag = "R2";
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] spm_rd_next = '0;

    logic [31:0] exp_rd_q[$];
    int          exp_spm_a[$];
    logic [31:0] exp_spm_d[$];
    logic [31:0] exp_wr_a[$];
    logic [31:0] exp_wr_d[$];
    int          pend_rdy[$];
    logic [31:0] pend_dat[$];
    logic [31:0] spm_model [0:6143];

    function automatic logic [31:0] ext_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h00C0_FFEE;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // memory, scratchpad model and scoreboard monitor
    initial begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        spm_rdata  = '0;
        for (int k = 0; k < 6144; k++) spm_model[k] = 32'h5000_0000 + 32'(k * 3);
        forever begin
            @(negedge clk);
            cyc++;
            lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
            mem_gnt = gnt_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
            if (pend_rdy.size() != 0 && pend_rdy[0] <= cyc) begin
                mem_rvalid = 1'b1;
                mem_rdata  = pend_dat.pop_front();
                void'(pend_rdy.pop_front());
            end else begin
                mem_rvalid = 1'b0;
            end
            spm_rdata = spm_rd_next;
            #5;
            if (mem_req || spm_en) act_cnt++;
            if (done) done_cnt++;
            if (mem_rvalid) track_out--;
            if (mem_req && mem_gnt && !mem_we) begin
                int lat;
                int rdy;
                if (exp_rd_q.size() == 0) check(1'b0, "R2 unexpected read", mem_addr, '0);
                else begin
                    logic [31:0] ea;
                    ea = exp_rd_q.pop_front();
                    check(mem_addr == ea, rd_tag, mem_addr, ea);
                end
                lat = lat_long ? 8 : 1 + int'(lfsr[7:5]) % 6;
                rdy = cyc + lat;
                if (rdy <= last_ready) rdy = last_ready + 1;
                last_ready = rdy;
                pend_rdy.push_back(rdy);
                pend_dat.push_back(ext_word(mem_addr));
                track_out++;
                if (track_out > max_out) max_out = track_out;
                check(track_out <= 4, "R5 outstanding", 32'(track_out), 32'd4);
            end
            if (mem_req && mem_gnt && mem_we) begin
                if (exp_wr_a.size() == 0) check(1'b0, "R3 unexpected write", mem_addr, '0);
                else begin
                    logic [31:0] wa;
                    logic [31:0] wd;
                    wa = exp_wr_a.pop_front();
                    wd = exp_wr_d.pop_front();
                    check(mem_addr == wa, "R3 write address", mem_addr, wa);
                    check(mem_wdata == wd, "R3 write data", mem_wdata, wd);
                end
            end
            if (spm_en && spm_we) begin
                if (exp_spm_a.size() == 0) check(1'b0, "R10 unexpected spm write", 32'(spm_addr), '0);
                else begin
                    int          sa;
                    logic [31:0] sd;
                    sa = exp_spm_a.pop_front();
                    sd = exp_spm_d.pop_front();
                    check(32'(spm_addr) == 32'(sa), "R10 spm write address", 32'(spm_addr), 32'(sa));
                    check(spm_wdata == sd, "R10 spm write data", spm_wdata, sd);
                end
                spm_model[spm_addr] = spm_wdata;
            end
            if (spm_en && !spm_we) spm_rd_next = spm_model[spm_addr];
        end
    end

    task automatic push_expect(input bit dir, input logic [31:0] ext, input int spm,
                               input int len, input int stride, input int cnt);
        int n = 0;
        for (int i = 0; i < cnt; i++) begin
            for (int j = 0; j < len; j++) begin
                logic [31:0] a;
                a = ext + 32'(i) * 32'(stride) + 32'(j);
                if (!dir) begin
                    exp_rd_q.push_back(a);
                    exp_spm_a.push_back(spm + n);
                    exp_spm_d.push_back(ext_word(a));
                end else begin
                    exp_wr_a.push_back(a);
                    exp_wr_d.push_back(spm_model[spm + n]);
                end
                n++;
            end
        end
    endtask

    task automatic pulse_start(input bit dir, input logic [31:0] ext, input int spm,
                               input int len, input int stride, input int cnt);
        @(negedge clk);
        cmd_start    = 1'b1;
        cmd_dir      = dir;
        cmd_ext_base = ext;
        cmd_spm_base = 13'(spm);
        cmd_blk_len  = 16'(len);
        cmd_stride   = 32'(stride);
        cmd_blk_cnt  = 16'(cnt);
        @(negedge clk);
        cmd_start = 1'b0;
        #6;
    endtask

    task automatic wait_done(input int d0);
        int guard = 0;
        while (done_cnt == d0 && guard < 20000) begin
            @(negedge clk);
            #6;
            guard++;
        end
        check(done_cnt != d0, "R6 done reached", 32'(done_cnt), 32'(d0 + 1));
    endtask

    // kind: 0 normal, 1 empty descriptor, 2 out of range
    task automatic run_xfer(input bit dir, input logic [31:0] ext, input int spm,
                            input int len, input int stride, input int cnt, input int kind);
        int d0;
        if (kind == 0) push_expect(dir, ext, spm, len, stride, cnt);
        d0 = done_cnt;
        act_cnt = 0;
        pulse_start(dir, ext, spm, len, stride, cnt);
        check(busy == 1'b1, "R6 busy after start", 32'(busy), 32'd1);
        if (kind == 1) check(done == 1'b1, "R7 immediate done", 32'(done), 32'd1);
        if (kind == 2) check(done == 1'b1, "R8 immediate done", 32'(done), 32'd1);
        wait_done(d0);
        @(negedge clk);
        #6;
        check(busy == 1'b0 && done == 1'b0, "R6 idle after done", {busy, done}, 32'd0);
        check(done_cnt == d0 + 1, "R6 single done pulse", 32'(done_cnt), 32'(d0 + 1));
        check(exp_rd_q.size() == 0 && exp_spm_a.size() == 0 && exp_wr_a.size() == 0,
              "R2 R3 all items seen", 32'(exp_rd_q.size() + exp_spm_a.size() + exp_wr_a.size()), 32'd0);
        check(err_range == (kind == 2), "R8 err_range", 32'(err_range), 32'(kind == 2));
        check(err_busy == 1'b0, "R9 err_busy clear", 32'(err_busy), 32'd0);
        if (kind == 1) check(act_cnt == 0, "R7 no access", 32'(act_cnt), 32'd0);
        if (kind == 2) check(act_cnt == 0, "R8 no access", 32'(act_cnt), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        summary_and_end();
    end

    initial begin
        int d0;
        rst_n = 1'b0;
        cmd_start = 1'b0; cmd_dir = 1'b0; cmd_ext_base = '0; cmd_spm_base = '0;
        cmd_blk_len = '0; cmd_stride = '0; cmd_blk_cnt = '0;
        repeat (3) @(negedge clk);
        #6;
        // R1
        check({busy, done, err_busy, err_range, mem_req, spm_en} == 6'b0, "R1 reset state",
              32'({busy, done, err_busy, err_range, mem_req, spm_en}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R10: strided load, steady grant
        run_xfer(1'b0, 32'h0000_1000, 100, 4, 10, 3, 0);
        // R2 R10: strided load, irregular grant
        gnt_rand = 1;
        run_xfer(1'b0, 32'hFFFF_FF00, 300, 5, 100, 4, 0);
        // R4 R5: contiguous load with long latency fills the window
        gnt_rand = 0; lat_long = 1; max_out = 0; rd_tag = "R4";
        run_xfer(1'b0, 32'h0002_0000, 2048, 32, 32, 1, 0);
        check(max_out == 4, "R5 window reached", 32'(max_out), 32'd4);
        rd_tag = "R2"; lat_long = 0;
        // R3: strided store, irregular grant
        gnt_rand = 1;
        run_xfer(1'b1, 32'h0003_0000, 100, 3, 7, 3, 0);
        // R3: contiguous store of freshly loaded words
        run_xfer(1'b1, 32'h0004_0000, 300, 20, 20, 1, 0);
        gnt_rand = 0;
        // R7: empty descriptors
        run_xfer(1'b0, 32'h0000_0000, 0, 0, 4, 3, 1);
        run_xfer(1'b1, 32'h0000_0000, 0, 4, 4, 0, 1);
        // R8: overrun rejected, exact fit accepted
        run_xfer(1'b0, 32'h0000_5000, 6136, 3, 3, 3, 2);
        run_xfer(1'b0, 32'h0000_6000, 6136, 4, 9, 2, 0);

        // R9: start while busy is ignored
        lat_long = 1;
        push_expect(1'b0, 32'h0007_0000, 500, 6, 50, 3);
        d0 = done_cnt;
        pulse_start(1'b0, 32'h0007_0000, 500, 6, 50, 3);
        repeat (3) @(negedge clk);
        pulse_start(1'b1, 32'h0009_0000, 0, 4, 4, 2);
        check(err_busy == 1'b1, "R9 err_busy set", 32'(err_busy), 32'd1);
        check(busy == 1'b1, "R9 transfer continues", 32'(busy), 32'd1);
        wait_done(d0);
        check(err_busy == 1'b1, "R9 err_busy sticky", 32'(err_busy), 32'd1);
        @(negedge clk);
        #6;
        check(exp_rd_q.size() == 0 && exp_spm_a.size() == 0 && exp_wr_a.size() == 0,
              "R9 only first transfer ran", 32'(exp_rd_q.size() + exp_spm_a.size() + exp_wr_a.size()), 32'd0);
        lat_long = 0;
        // R9: next accepted start clears the flag
        run_xfer(1'b0, 32'h0000_0000, 0, 0, 1, 1, 1);
        // R8 then R9: range flag clears on next accepted start
        run_xfer(1'b0, 32'h0000_0000, 6000, 100, 100, 2, 2);
        run_xfer(1'b0, 32'h0000_8000, 10, 2, 5, 2, 0);

        summary_and_end();
    end

endmodule